// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous 512K x 8 Static RAM

This block connects a synchronous system to an external asynchronous static RAM that holds 512K bytes. The user side gives one request at a time: a valid strobe, a write flag, a 19-bit byte address and, for writes, one data byte. When the block is idle it accepts the request and runs a full memory cycle on the active-low chip-enable, write-enable and output-enable pins, the address bus and a shared tri-state data bus. It then pulses an acknowledge for one clock. For a read, the data byte comes out with that acknowledge.

Every phase length is computed at elaboration time. Each memory minimum in nanoseconds is divided by a clock-period parameter and rounded up. A write is one write-enable-low window with chip enable low and output enable high. The controller drives the data bus only inside that window, so the rising edge of write enable ends the write and releases the bus. A read holds output enable low until both the address-access time and the output-enable-access time have passed, then captures the byte and raises output enable. The bus is given back before the controller drives it again, and the controller drives nothing before the next read opens the memory outputs.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, and whenever no cycle is running, chip enable, write enable and output enable are all high, the data bus is released (high impedance), `req_ready` is 1 and `rsp_ack` is 0.
- R2: A write holds chip enable and write enable low for WE_CYC = ceil(max(50, 60, 60, 30) ns / period) clocks (3 at 20 ns). Output enable stays high for the whole write. The controller drives the data bus only while write enable is low.
- R3: The byte on `req_wdata` and the full 19-bit `req_addr`, both latched at acceptance, are what the memory holds when write enable rises.
- R4: A read holds chip enable and output enable low with write enable high for RD_CYC = ceil(max(70, 35, 70) ns / period) clocks (4 at 20 ns). It captures the bus on the edge that ends this window.
- R5: `rsp_ack` is high for exactly one clock per finished cycle. After a read, `rsp_rdata` carries the captured byte in that clock and keeps it until the next read completes. A write leaves it unchanged.
- R6: A request is taken only when `req_ready` is 1. A request raised while a cycle runs is ignored: it produces no acknowledge and no memory access.
- R7: After a read, the controller does not drive the data bus for at least ceil(25 ns / period) clocks after output enable rises (2 at 20 ns). Output enable never falls in the clock right after the controller drove the bus.
- R8: Counted from the accepting edge, a write acknowledges after WE_CYC + max(ceil(70/period) - WE_CYC, 1) clocks (4 at 20 ns). A read acknowledges after RD_CYC + max(ceil(25/period), 1) clocks (6 at 20 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle, able to take a request |
| rsp_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read data, valid with acknowledge |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 19 | Memory address bus |
| sram_dq | inout | 8 | Memory data bus, tri-state |

## Verification
At the default 20 ns period, a write's acknowledge is due 4 clocks after the accepting edge and a read's is due 6 clocks after it. Write enable is low for 3 clocks and output enable for 4. The bench drives inputs on falling edges and counts falling edges from acceptance to the acknowledge. It compares that count, and the strobe run lengths its monitor measures, against values it derives again from the nanosecond minimums. Its memory model returns a wrong byte if output enable has been low for less than the access time, so a read that ends too early is caught as a data mismatch.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WRITE   = 2'd1,
    ST_READ    = 2'd2,
    ST_RECOVER = 2'd3
  } sram_state_e;

  // Clocks needed to cover a nanosecond minimum (rounded up).
  function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Non-negative difference.
  function automatic int unsigned sub0(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned WE_CYC = 3,
  parameter int unsigned RD_CYC = 4,
  parameter int unsigned WR_REC = 1,
  parameter int unsigned RD_REC = 2,
  parameter int unsigned CNT_W  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  output logic        accept,
  output sram_state_e state,
  output logic        rd_sample,
  output logic        done
);

  sram_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             op_wr_q;
  logic             phase_end;

  always_comb begin
    case (state_q)
      ST_WRITE:   last_cnt = CNT_W'(WE_CYC - 1);
      ST_READ:    last_cnt = CNT_W'(RD_CYC - 1);
      ST_RECOVER: last_cnt = op_wr_q ? CNT_W'(WR_REC - 1) : CNT_W'(RD_REC - 1);
      default:    last_cnt = '0;
    endcase
  end

  assign phase_end = (cnt_q == last_cnt);
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign rd_sample = (state_q == ST_READ) && phase_end;
  assign state     = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_wr_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= (state_q == ST_RECOVER) && phase_end;
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (accept) begin
            op_wr_q <= req_write;
            state_q <= req_write ? ST_WRITE : ST_READ;
          end
        end
        default: begin
          if (phase_end) begin
            cnt_q   <= '0;
            state_q <= (state_q == ST_RECOVER) ? ST_IDLE : ST_RECOVER;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state_q != ST_IDLE) && !done); // R6

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_sample,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_sample) begin
        rdata_q <= bus_in;
      end
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned T_WC_NS       = 70,
  parameter int unsigned T_PWE_NS      = 50,
  parameter int unsigned T_AW_NS       = 60,
  parameter int unsigned T_SCE_NS      = 60,
  parameter int unsigned T_SD_NS       = 30,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_AA_NS       = 70,
  parameter int unsigned T_DOE_NS      = 35,
  parameter int unsigned T_HZOE_NS     = 25,
  parameter int unsigned TURN_CYC      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [DATA_W-1:0] sram_dq
);

  localparam int unsigned P      = CLK_PERIOD_NS;
  localparam int unsigned WE_CYC = max2(1, max2(max2(ns_to_clk(T_PWE_NS, P), ns_to_clk(T_SD_NS, P)),
                                               max2(ns_to_clk(T_AW_NS, P), ns_to_clk(T_SCE_NS, P))));
  localparam int unsigned WR_REC = max2(max2(TURN_CYC, 1), sub0(ns_to_clk(T_WC_NS, P), WE_CYC));
  localparam int unsigned RD_CYC = max2(1, max2(ns_to_clk(T_RC_NS, P),
                                               max2(ns_to_clk(T_AA_NS, P), ns_to_clk(T_DOE_NS, P))));
  localparam int unsigned RD_REC = max2(max2(TURN_CYC, 1), ns_to_clk(T_HZOE_NS, P));
  localparam int unsigned MAX_PH = max2(max2(WE_CYC, RD_CYC), max2(WR_REC, RD_REC));
  localparam int unsigned CNT_W  = $clog2(MAX_PH + 1);
  localparam int unsigned RUN_W  = CNT_W + 1;

  sram_state_e       state;
  logic              accept;
  logic              rd_sample;
  logic              drv_en;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] bus_in;

  sram_ctl_seq #(
    .WE_CYC(WE_CYC), .RD_CYC(RD_CYC), .WR_REC(WR_REC), .RD_REC(RD_REC), .CNT_W(CNT_W)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .accept(accept), .state(state), .rd_sample(rd_sample), .done(rsp_ack)
  );

  sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_sample(rd_sample), .bus_in(bus_in),
    .addr_q(sram_addr), .wdata_q(wdata_q), .rdata_q(rsp_rdata)
  );

  // Strobes decoded from the state register.
  assign req_ready = (state == ST_IDLE);
  assign sram_ce_n = !((state == ST_WRITE) || (state == ST_READ));
  assign sram_we_n = (state != ST_WRITE);
  assign sram_oe_n = (state != ST_READ);
  assign drv_en    = (state == ST_WRITE);

  assign sram_dq = drv_en ? wdata_q : {DATA_W{1'bz}};
  assign bus_in  = sram_dq;

  // Run-length counters that observe the pins, for the timing checks.
  logic [RUN_W-1:0] we_low_run;
  logic [RUN_W-1:0] oe_low_run;
  logic [RUN_W-1:0] oe_high_run;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_run  <= '0;
      oe_low_run  <= '0;
      oe_high_run <= RUN_MAX;
    end else begin
      we_low_run  <= sram_we_n ? '0 : ((we_low_run == RUN_MAX) ? RUN_MAX : we_low_run + 1'b1);
      oe_low_run  <= sram_oe_n ? '0 : ((oe_low_run == RUN_MAX) ? RUN_MAX : oe_low_run + 1'b1);
      oe_high_run <= !sram_oe_n ? '0 : ((oe_high_run == RUN_MAX) ? RUN_MAX : oe_high_run + 1'b1);
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !drv_en)); // R1
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_ce_n)); // R2
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_run >= RUN_W'(WE_CYC))); // R2
  AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (oe_low_run >= RUN_W'(RD_CYC))); // R4
  AST_TURN_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> (oe_high_run >= RUN_W'(RD_REC))); // R7
  AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n) |-> !$past(drv_en)); // R7

endmodule

// File: tb/test_sram_async_ctl.sv
module test_sram_async_ctl;

  localparam int unsigned PER = 20;

  function automatic int unsigned clk_up(input int unsigned ns);
    int unsigned c;
    c = ns / PER;
    if (c * PER < ns) c = c + 1;
    return c;
  endfunction

  // Expected values restated from the requirements.
  localparam int unsigned E_WE  = 3;   // ceil(60/20)
  localparam int unsigned E_OE  = 4;   // ceil(70/20)
  localparam int unsigned E_WLAT = 4;  // 3 + max(4-3,1)
  localparam int unsigned E_RLAT = 6;  // 4 + max(2,1)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_ack;
  logic [7:0]  rsp_rdata;
  logic        sram_ce_n, sram_we_n, sram_oe_n;
  logic [18:0] sram_addr;
  wire  [7:0]  sram_dq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sram_async_ctl i_sram_async_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_addr(sram_addr),
    .sram_dq(sram_dq)
  );

  // ---------------- memory model ----------------
  logic [7:0]  mem [512];
  logic [7:0]  pend_d;
  logic [18:0] pend_a;
  bit          pend_v = 1'b0;
  logic [18:0] last_waddr = '0;
  int          rd_cnt = 0;
  int          hold = 0;
  logic        m_active;
  logic        m_drv;
  logic [7:0]  m_q;
  wire         wterm = sram_ce_n | sram_we_n;

  initial for (int i = 0; i < 512; i++) mem[i] = 8'h00;

  assign m_active = !sram_ce_n && !sram_oe_n && sram_we_n;
  assign m_drv    = m_active || (hold != 0);
  assign m_q      = (m_active && ((rd_cnt + 1) * PER >= 70)) ? mem[sram_addr[8:0]] : 8'hEE;
  assign sram_dq  = m_drv ? m_q : 8'bzzzzzzzz;

  always @(posedge clk) begin
    rd_cnt <= m_active ? rd_cnt + 1 : 0;
    hold   <= m_active ? clk_up(25) : ((hold > 0) ? hold - 1 : 0);
  end

  always @(negedge clk) begin
    if (!sram_ce_n && !sram_we_n) begin
      pend_d <= sram_dq;
      pend_a <= sram_addr;
      pend_v <= 1'b1;
    end
  end

  always @(posedge wterm) begin
    if (pend_v) begin
      mem[pend_a[8:0]] = pend_d;
      last_waddr = pend_a;
      pend_v = 1'b0;
    end
  end

  // ---------------- pin monitor ----------------
  int we_run = 0, oe_run = 0, we_len = 0, oe_len = 0;
  int oe_in_write = 0, ctl_stray = 0, contention = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!sram_we_n) we_run++; else begin if (we_run != 0) we_len = we_run; we_run = 0; end
      if (!sram_oe_n) oe_run++; else begin if (oe_run != 0) oe_len = oe_run; oe_run = 0; end
      if (!sram_we_n && !sram_oe_n) oe_in_write++;
      if (sram_we_n && !m_drv && (sram_dq !== 8'bzzzzzzzz)) ctl_stray++;
      if (m_drv && $isunknown(sram_dq)) contention++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Runs one request; returns clocks from acceptance to ack and the read data.
  task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                       output int lat, output logic [7:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_ack && lat < 50) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    rd = rsp_rdata;
  endtask

  localparam logic [27:0] VEC [0:7] = '{
    {1'b1, 19'h00012, 8'hA5},
    {1'b1, 19'h7FFFF, 8'h3C},
    {1'b1, 19'h00100, 8'hFF},
    {1'b0, 19'h00012, 8'hA5},
    {1'b0, 19'h7FFFF, 8'h3C},
    {1'b1, 19'h00012, 8'h5A},
    {1'b0, 19'h00012, 8'h5A},
    {1'b0, 19'h00100, 8'hFF}
  };

  initial begin
    #(200000 * PER);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [7:0] rd;
    logic [7:0] prev_rd;
    int acks;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes", {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
    check(sram_dq === 8'bzzzzzzzz && req_ready && !rsp_ack, "R1 bus/ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_ack, "R1 after release", int'(req_ready), 1);

    prev_rd = 8'h00;
    for (int i = 0; i < 8; i++) begin
      logic [27:0] v;
      v = VEC[i];
      do_op(v[27], v[26:8], v[7:0], lat, rd);
      if (v[27]) begin
        check(lat == E_WLAT, "R8 write latency", lat, E_WLAT);
        check(we_len == E_WE, "R2 we width", we_len, E_WE);
        check(mem[v[16:8]] == v[7:0], "R3 stored data", mem[v[16:8]], v[7:0]);
        check(last_waddr == v[26:8], "R3 full address", last_waddr, v[26:8]);
        check(rd == prev_rd, "R5 rdata held over write", rd, prev_rd);
      end else begin
        check(lat == E_RLAT, "R8 read latency", lat, E_RLAT);
        check(oe_len == E_OE, "R4 oe width", oe_len, E_OE);
        check(rd == v[7:0], "R4 read data", rd, v[7:0]);
        prev_rd = rd;
      end
      @(negedge clk);
      check(!rsp_ack, "R5 ack one clock", int'(rsp_ack), 0);
    end

    // R6: a request raised while busy is ignored
    do_op(1'b1, 19'h00055, 8'h11, lat, rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00055; req_wdata = 8'h11;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    req_addr = 19'h00066; req_wdata = 8'h22;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    acks = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (rsp_ack) acks++;
    end
    check(acks == 1, "R6 single ack while busy", acks, 1);
    do_op(1'b0, 19'h00066, 8'h00, lat, rd);
    check(rd == 8'h00, "R6 ignored write not stored", rd, 8'h00);
    do_op(1'b0, 19'h00055, 8'h00, lat, rd);
    check(rd == 8'h11, "R6 accepted write stored", rd, 8'h11);

    // R7: read directly followed by write, then read
    do_op(1'b1, 19'h00077, 8'hC3, lat, rd);
    do_op(1'b0, 19'h00077, 8'h00, lat, rd);
    check(rd == 8'hC3, "R7 read after write", rd, 8'hC3);
    do_op(1'b1, 19'h00078, 8'h3C, lat, rd);
    do_op(1'b0, 19'h00078, 8'h00, lat, rd);
    check(rd == 8'h3C, "R7 write after read", rd, 8'h3C);

    repeat (3) @(negedge clk);
    check(contention == 0, "R7 no bus contention", contention, 0);
    check(ctl_stray == 0, "R2 drive only while we low", ctl_stray, 0);
    check(oe_in_write == 0, "R2 oe high during write", oe_in_write, 0);
    check(req_ready && sram_ce_n && sram_we_n && sram_oe_n && (sram_dq === 8'bzzzzzzzz),
          "R1 idle standby", int'(req_ready), 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule